// File: doc/BRIEF.md
# Byte-Lane Write Mask and Bus Inversion Unit

This unit sits on one byte lane of a double-data-rate memory path. It handles both transfer directions. Each clock carries two beats of the lane, with beat 0 in the low byte of every bus, so the two edges of a transfer are seen as two words per clock.

A single lane signal, active low, is shared between two jobs. In mask mode it marks write beats that must not reach storage. In inversion mode it tells whether the data on the wire for a beat is the bitwise complement of the true data. Two static configuration bits choose the mode. Requesting both modes at once is illegal and is flagged.

On writes, the unit turns the wire data and the lane bits into true data plus one byte enable per beat for the storage array. On reads, it takes true data from storage and produces the wire data and lane bits. In inversion mode it inverts any beat that would otherwise drive too many zeros onto the bus. Both paths are registered, with one clock of latency.

Top module: `lane_mask_dbi`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), st_valid_o and rd_valid_o are 0, st_data_o, st_be_o and rd_dq_o are all zeros, and rd_pin_o is all ones.
- R2: st_valid_o equals wr_valid_i of the previous clock, and rd_valid_o equals rd_valid_i of the previous clock.
- R3: In mask mode (cfg_mask_en=1, cfg_inv_en=0), st_be_o bit b equals wr_pin_i bit b. A low lane bit masks beat b and gives enable 0. The write data is passed unchanged.
- R4: In inversion mode (cfg_inv_en=1, cfg_mask_en=0), write beat b is stored complemented when wr_pin_i bit b is 0 and unchanged when it is 1. All byte enables are 1.
- R5: In inversion mode, a read beat whose true data has more than W/2 zero bits is output complemented, with rd_pin_o bit b = 0. Any other beat, including one with exactly W/2 zeros, is output unchanged with rd_pin_o bit b = 1.
- R6: In mask mode, reads drive rd_pin_o all ones and output the true data.
- R7: With both modes disabled, wr_pin_i has no effect: data is unchanged and all byte enables are 1. Reads drive rd_pin_o all ones with true data.
- R8: cfg_error is 1 exactly when cfg_mask_en and cfg_inv_en are both 1. In that state the lane behaves as described in R7.
- R9: In a cycle where st_valid_o is 0, st_data_o and st_be_o are zero. In a cycle where rd_valid_o is 0, rd_dq_o is zero and rd_pin_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mask_en | input | 1 | Static: enable write masking |
| cfg_inv_en | input | 1 | Static: enable bus inversion |
| cfg_error | output | 1 | Both modes requested |
| wr_valid_i | input | 1 | Write beats present |
| wr_dq_i | input | W*BEATS | Write data as seen on the wire |
| wr_pin_i | input | BEATS | Lane bit for each write beat, active low |
| st_valid_o | output | 1 | Storage write valid |
| st_data_o | output | W*BEATS | True data towards storage |
| st_be_o | output | BEATS | Byte enable for each beat |
| rd_valid_i | input | 1 | Read beats present |
| rd_data_i | input | W*BEATS | True data from storage |
| rd_valid_o | output | 1 | Read wire data valid |
| rd_dq_o | output | W*BEATS | Read data for the wire |
| rd_pin_o | output | BEATS | Lane bit for each read beat |

## Verification
The bench targets a read beat with exactly four zeros. A design that used "at least" in place of "more than" would invert that beat and pull its lane bit low.

It also drives the two beats of one clock with different lane bits in both directions. A design that shared one mask or inversion decision across the beats, or swapped the beat order, would corrupt one byte.

It exercises the disabled and illegal configurations with the lane bit low. A design that still honoured the pin there would drop or invert data.

Finally, it checks idle cycles. A design that left stale enables active would write storage while nothing is valid.

// File: rtl/lane_mask_dbi.sv
module lane_mask_dbi #(
  parameter int W     = 8,
  parameter int BEATS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mask_en,
  input  logic                 cfg_inv_en,
  output logic                 cfg_error,
  input  logic                 wr_valid_i,
  input  logic [W*BEATS-1:0]   wr_dq_i,
  input  logic [BEATS-1:0]     wr_pin_i,
  output logic                 st_valid_o,
  output logic [W*BEATS-1:0]   st_data_o,
  output logic [BEATS-1:0]     st_be_o,
  input  logic                 rd_valid_i,
  input  logic [W*BEATS-1:0]   rd_data_i,
  output logic                 rd_valid_o,
  output logic [W*BEATS-1:0]   rd_dq_o,
  output logic [BEATS-1:0]     rd_pin_o
);
  localparam int TW   = W * BEATS;
  localparam int CW   = $clog2(W + 1);
  localparam int HALF = W / 2;

  logic          mask_on, inv_on;
  logic [TW-1:0] w_data, r_data;
  logic [BEATS-1:0] w_be, r_pin;

  assign cfg_error = cfg_mask_en & cfg_inv_en;
  assign mask_on   = cfg_mask_en & ~cfg_inv_en;
  assign inv_on    = cfg_inv_en & ~cfg_mask_en;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic [W-1:0]  wbeat, rbeat;
    logic [CW-1:0] zeros;
    logic          flip;

    assign wbeat = wr_dq_i[b*W +: W];
    assign rbeat = rd_data_i[b*W +: W];

    assign w_data[b*W +: W] = (inv_on && !wr_pin_i[b]) ? ~wbeat : wbeat;
    assign w_be[b]          = mask_on ? wr_pin_i[b] : 1'b1;

    always_comb begin
      zeros = '0;
      for (int i = 0; i < W; i++)
        zeros = zeros + {{(CW-1){1'b0}}, ~rbeat[i]};
    end

    assign flip             = inv_on && (zeros > CW'(HALF));
    assign r_data[b*W +: W] = flip ? ~rbeat : rbeat;
    assign r_pin[b]         = ~flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid_o <= 1'b0;
      st_data_o  <= '0;
      st_be_o    <= '0;
    end else begin
      st_valid_o <= wr_valid_i;
      st_data_o  <= wr_valid_i ? w_data : '0;
      st_be_o    <= wr_valid_i ? w_be : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_dq_o    <= '0;
      rd_pin_o   <= '1;
    end else begin
      rd_valid_o <= rd_valid_i;
      rd_dq_o    <= rd_valid_i ? r_data : '0;
      rd_pin_o   <= rd_valid_i ? r_pin : '1;
    end
  end
endmodule

// File: rtl/lane_mask_dbi_chk.sv
module lane_mask_dbi_chk #(
  parameter int W     = 8,
  parameter int BEATS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_mask_en,
  input logic               cfg_inv_en,
  input logic               cfg_error,
  input logic               wr_valid_i,
  input logic [W*BEATS-1:0] wr_dq_i,
  input logic [BEATS-1:0]   wr_pin_i,
  input logic               st_valid_o,
  input logic [W*BEATS-1:0] st_data_o,
  input logic [BEATS-1:0]   st_be_o,
  input logic               rd_valid_i,
  input logic [W*BEATS-1:0] rd_data_i,
  input logic               rd_valid_o,
  input logic [W*BEATS-1:0] rd_dq_o,
  input logic [BEATS-1:0]   rd_pin_o
);
  a_r2_wr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i |=> st_valid_o);
  a_r2_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> rd_valid_o);
  a_r9_be_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid_o |-> st_be_o == '0);
  a_r9_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> &rd_pin_o);
  a_r3_mask_be: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && $past(cfg_mask_en && !cfg_inv_en)) |-> st_be_o == $past(wr_pin_i));
  a_r6_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !$past(cfg_inv_en && !cfg_mask_en)) |-> &rd_pin_o);

  for (genvar b = 0; b < BEATS; b++) begin : g_chk
    a_r5_ones_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && $past(cfg_inv_en && !cfg_mask_en)) |->
        $countones(rd_dq_o[b*W +: W]) >= W/2);
    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> (rd_pin_o[b] ? rd_dq_o[b*W +: W] : ~rd_dq_o[b*W +: W])
                     == $past(rd_data_i[b*W +: W]));
    a_r4_wr_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid_o && $past(cfg_inv_en && !cfg_mask_en)) |->
        st_data_o[b*W +: W] == ($past(wr_pin_i[b]) ? $past(wr_dq_i[b*W +: W])
                                                   : ~$past(wr_dq_i[b*W +: W])));
  end
endmodule

bind lane_mask_dbi lane_mask_dbi_chk #(.W(W), .BEATS(BEATS)) u_chk (.*);

// File: tb/lane_mask_dbi_tb.sv
`timescale 1ns/1ps
module lane_mask_dbi_tb;
  localparam int W = 8, BEATS = 2, TW = 16, NV = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mask_en = 1'b0, cfg_inv_en = 1'b0, cfg_error;
  logic wr_valid_i = 1'b0, rd_valid_i = 1'b0;
  logic [TW-1:0] wr_dq_i = '0, rd_data_i = '0, st_data_o, rd_dq_o;
  logic [BEATS-1:0] wr_pin_i = '1, st_be_o, rd_pin_o;
  logic st_valid_o, rd_valid_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_mask_dbi #(.W(W), .BEATS(BEATS)) u_dut (.*);

  // {mode(inv,mask), wpin, wdq, rdat, exp st_data, exp be, exp rd_dq, exp rd_pin}
  localparam logic [71:0] VEC [NV] = '{
    {2'b01, 2'b10, 16'hA55A, 16'h0F00, 16'hA55A, 2'b10, 16'h0F00, 2'b11},
    {2'b01, 2'b01, 16'h1234, 16'hFFFF, 16'h1234, 2'b01, 16'hFFFF, 2'b11},
    {2'b10, 2'b01, 16'h0F3C, 16'h0100, 16'hF03C, 2'b11, 16'hFEFF, 2'b00},
    {2'b10, 2'b00, 16'hFF00, 16'h0F33, 16'h00FF, 2'b11, 16'h0F33, 2'b11},
    {2'b10, 2'b11, 16'hABCD, 16'h07E0, 16'hABCD, 2'b11, 16'hF81F, 2'b00},
    {2'b10, 2'b10, 16'h5501, 16'h80FF, 16'h55FE, 2'b11, 16'h7FFF, 2'b01},
    {2'b00, 2'b00, 16'hC3C3, 16'h0000, 16'hC3C3, 2'b11, 16'h0000, 2'b11},
    {2'b11, 2'b00, 16'h1E1E, 16'h0001, 16'h1E1E, 2'b11, 16'h0001, 2'b11},
    {2'b01, 2'b00, 16'hFFFF, 16'h0000, 16'hFFFF, 2'b00, 16'h0000, 2'b11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R1 st_valid", 32'(st_valid_o), 0);
    chk("R1 st_data", 32'(st_data_o), 0);
    chk("R1 st_be", 32'(st_be_o), 0);
    chk("R1 rd_valid", 32'(rd_valid_o), 0);
    chk("R1 rd_dq", 32'(rd_dq_o), 0);
    chk("R1 rd_pin", 32'(rd_pin_o), 32'h3);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string tw, tr;
      logic [71:0] e;
      e = VEC[v];
      case (e[71:70])
        2'b01: begin tw = "R3"; tr = "R6"; end
        2'b10: begin tw = "R4"; tr = "R5"; end
        2'b00: begin tw = "R7"; tr = "R7"; end
        default: begin tw = "R8"; tr = "R8"; end
      endcase
      @(negedge clk);
      {cfg_inv_en, cfg_mask_en} = e[71:70];
      wr_pin_i = e[69:68]; wr_dq_i = e[67:52]; rd_data_i = e[51:36];
      wr_valid_i = 1'b1; rd_valid_i = 1'b1;
      #1 chk("R8 cfg_error", 32'(cfg_error), 32'(e[71:70] == 2'b11));
      @(negedge clk);
      chk({tw, " st_data"}, 32'(st_data_o), 32'(e[35:20]));
      chk({tw, " st_be"}, 32'(st_be_o), 32'(e[19:18]));
      chk({tr, " rd_dq"}, 32'(rd_dq_o), 32'(e[17:2]));
      chk({tr, " rd_pin"}, 32'(rd_pin_o), 32'(e[1:0]));
      chk("R2 valids", {30'd0, st_valid_o, rd_valid_o}, 32'h3);
    end

    // R9 idle after activity; R2 valid drops one clock after inputs drop
    wr_valid_i = 1'b0; rd_valid_i = 1'b0;
    @(negedge clk);
    chk("R2 st_valid drop", 32'(st_valid_o), 0);
    chk("R9 st_be idle", 32'(st_be_o), 0);
    chk("R9 st_data idle", 32'(st_data_o), 0);
    chk("R9 rd_pin idle", 32'(rd_pin_o), 32'h3);
    chk("R9 rd_dq idle", 32'(rd_dq_o), 0);

    // R2 write only, read side stays idle (inversion mode, read data all zeros)
    cfg_inv_en = 1'b1; cfg_mask_en = 1'b0;
    wr_valid_i = 1'b1; wr_pin_i = 2'b00; wr_dq_i = 16'h0000; rd_data_i = 16'h0000;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk("R2 st_valid", 32'(st_valid_o), 1);
    chk("R4 st_data both inverted", 32'(st_data_o), 32'hFFFF);
    chk("R2 rd_valid idle", 32'(rd_valid_o), 0);
    chk("R9 rd_pin idle", 32'(rd_pin_o), 32'h3);

    // R1 asynchronous reset mid-stream
    rd_valid_i = 1'b1;
    @(negedge clk);
    chk("R5 all zero read", 32'(rd_pin_o), 0);
    #2 rst_n = 1'b0;
    #1 chk("R1 async rd_pin", 32'(rd_pin_o), 32'h3);
    chk("R1 async rd_valid", 32'(rd_valid_o), 0);
    rd_valid_i = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule